// File: doc/BRIEF.md
# Stop-Mode Wake Stabilization Controller

This block handles the low-power stop state of a small processor core. A stop request strobe halts the oscillator and gates the CPU clock. An external interrupt wakes the block. The block then restarts the oscillator and holds the CPU clock enable low while the oscillator settles. The settling delay comes from a fixed divide-by-16 stage that drives an 8-bit prescaler, which in turn drives an 8-bit timer. The CPU clock enable returns only when the timer underflows.

At wake-up the prescaler and timer are normally loaded with built-in start values: timer 0x01 and prescaler 0xFF. Together these give 16 × 256 × 2 = 8192 oscillator cycles of settling. Software can set an inhibit bit to suppress this automatic load. The counters then start from reload values that software wrote earlier. A separate stop-disable bit can be set by software but not cleared. Only reset clears it.

The controller has three states:
- RUN: the oscillator runs and the CPU clock is enabled.
- STOP: the oscillator is halted and the CPU clock is gated.
- SETTLE: the oscillator runs, the CPU clock is gated, and the counters are counting.

It has three transitions:
- RUN→STOP on an accepted stop request.
- STOP→SETTLE on a wake interrupt, which also loads the counters.
- SETTLE→RUN on a timer underflow.

Top module: `stopwake_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is in RUN with `cpu_clk_en`=1 and `osc_en`=1, and both control bits are 0. The first stop request after reset is therefore accepted.
- R2: In RUN, a `stop_req` pulse with stop-disable=0 sets `cpu_clk_en`=0 and `osc_en`=0 from the next cycle. Both stay 0 until a wake interrupt arrives.
- R3: In RUN, a `stop_req` pulse while stop-disable=1 is ignored: `cpu_clk_en` and `osc_en` stay 1.
- R4: In STOP, a `wake_irq` pulse sets `osc_en`=1 from the next cycle, while `cpu_clk_en` stays 0.
- R5: With reload-inhibit=0, the counters load timer=0x01 and prescaler=0xFF at wake. `cpu_clk_en` then rises exactly 8192 cycles after the wake edge, whatever reload values were written.
- R6: With reload-inhibit=1, the counters load the written reload values T and P at wake. `cpu_clk_en` rises exactly 16×(P+1)×(T+1) cycles after the wake edge.
- R7: The stop-disable bit is write-once. After it is written to 1, a later control write with bit 1 = 0 leaves it at 1, and stop requests stay ignored.
- R8: A `wake_irq` or `stop_req` pulse during SETTLE has no effect, so the settling length is unchanged.
- R9: A `wake_irq` pulse in RUN has no effect: `cpu_clk_en` and `osc_en` stay 1.
- R10: The write port uses three select codes: `wr_sel`=0 writes the timer reload value and `wr_sel`=1 writes the prescaler reload value. `wr_sel`=2 writes the control register, where bit 0 is reload-inhibit and bit 1 is stop-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop request strobe |
| wake_irq | input | 1 | External interrupt wake signal |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 timer, 1 prescaler, 2 control) |
| wr_data | input | 8 | Register write data |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator run enable |

## Verification
A table of vectors drives the stop–wake cycle with different combinations of inhibit bit and reload values.

With inhibit clear, the vectors use arbitrary and zero reload values. Each must give the same 8192-cycle delay, which shows that the fixed start values are used. With inhibit set, the vectors use smallest, asymmetric and maximum reload values. Each length then tells apart the prescaler and timer terms and any off-by-one error in the divider or the underflow.

Directed tests cover the remaining cases:
- interrupts and stop requests injected in the middle of settling;
- wake pulses while running;
- attempts to clear the stop-disable bit;
- a reset that must clear the stop-disable bit again.

// File: rtl/swk_pkg.sv
package swk_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2
    } swk_state_t;

    localparam logic [1:0] SEL_TMR  = 2'd0;
    localparam logic [1:0] SEL_PSC  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTRL_INHIBIT_BIT = 0;
    localparam int CTRL_STOPDIS_BIT = 1;
endpackage

// File: rtl/swk_regs.sv
module swk_regs
    import swk_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TMR_W = 8,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [TMR_W-1:0] tmr_rld,
    output logic [PSC_W-1:0] psc_rld,
    output logic             rld_inhibit,
    output logic             stop_dis
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_rld     <= '0;
            psc_rld     <= '0;
            rld_inhibit <= 1'b0;
            stop_dis    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_TMR:  tmr_rld <= wr_data[TMR_W-1:0];
                SEL_PSC:  psc_rld <= wr_data[PSC_W-1:0];
                SEL_CTRL: begin
                    rld_inhibit <= wr_data[CTRL_INHIBIT_BIT];
                    stop_dis    <= stop_dis | wr_data[CTRL_STOPDIS_BIT];
                end
                default: ;
            endcase
        end
    end

    // R7: once set, stop-disable never drops while out of reset
    p_stopdis_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_dis) |-> stop_dis);

    // R10: a control write updates the inhibit bit to the written bit 0
    p_inhibit_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (rld_inhibit == $past(wr_data[CTRL_INHIBIT_BIT])));
endmodule

// File: rtl/swk_downcnt.sv
module swk_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick_in,
    output logic         tick_out
);
    logic [W-1:0] cnt;
    logic [W-1:0] rld;

    assign tick_out = en && tick_in && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            rld <= '0;
        end else if (load) begin
            cnt <= load_val;
            rld <= load_val;
        end else if (en && tick_in) begin
            if (cnt == '0) cnt <= rld;
            else           cnt <= cnt - 1'b1;
        end
    end

    // R6: after an underflow the stage restarts from its start value
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && !load) |=> (cnt == rld));

    // R5: without a step input the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(en && tick_in)) |=> $stable(cnt));
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake_irq,
    input  logic       stop_dis,
    input  logic       tmr_uf,
    output swk_state_t state,
    output logic       cnt_load,
    output logic       settling,
    output logic       cpu_clk_en,
    output logic       osc_en
);
    swk_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (stop_req && !stop_dis) nxt = ST_STOP;
            ST_STOP:   if (wake_irq)              nxt = ST_SETTLE;
            ST_SETTLE: if (tmr_uf)                nxt = ST_RUN;
            default:                              nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        cnt_load   = 1'b0;
        settling   = 1'b0;
        cpu_clk_en = 1'b0;
        osc_en     = 1'b1;
        unique case (state)
            ST_RUN:    cpu_clk_en = 1'b1;
            ST_STOP: begin
                osc_en   = 1'b0;
                cnt_load = wake_irq;
            end
            ST_SETTLE: settling = 1'b1;
            default:   cpu_clk_en = 1'b1;
        endcase
    end

    // R3: a blocked stop request leaves the block running
    p_stop_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && stop_dis) |=> (state == ST_RUN));

    // R5: the CPU clock comes back only on a timer underflow
    p_release_on_uf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> $past(tmr_uf));

    // R8: settling continues until the timer underflows, whatever else arrives
    p_settle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !tmr_uf) |=> (state == ST_SETTLE));

    // R9: without a stop request the run state is kept
    p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !stop_req) |=> (state == ST_RUN));
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import swk_pkg::*;
#(
    parameter int                 DW      = 8,
    parameter int                 DIV_W   = 4,
    parameter int                 PSC_W   = 8,
    parameter int                 TMR_W   = 8,
    parameter logic [TMR_W-1:0]   DEF_TMR = 8'h01,
    parameter logic [PSC_W-1:0]   DEF_PSC = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop_req,
    input  logic          wake_irq,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          cpu_clk_en,
    output logic          osc_en
);
    localparam logic [DIV_W-1:0] DIV_START = {DIV_W{1'b1}};

    logic [TMR_W-1:0] tmr_rld, tmr_start;
    logic [PSC_W-1:0] psc_rld, psc_start;
    logic             rld_inhibit, stop_dis;
    logic             cnt_load, settling;
    logic             div_uf, psc_uf, tmr_uf;
    swk_state_t       state;

    swk_regs #(.DW(DW), .TMR_W(TMR_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tmr_rld(tmr_rld), .psc_rld(psc_rld),
        .rld_inhibit(rld_inhibit), .stop_dis(stop_dis)
    );

    assign tmr_start = rld_inhibit ? tmr_rld : DEF_TMR;
    assign psc_start = rld_inhibit ? psc_rld : DEF_PSC;

    swk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
        .stop_dis(stop_dis), .tmr_uf(tmr_uf), .state(state),
        .cnt_load(cnt_load), .settling(settling),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en)
    );

    swk_downcnt #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(settling), .load(cnt_load),
        .load_val(DIV_START), .tick_in(1'b1), .tick_out(div_uf)
    );

    swk_downcnt #(.W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(settling), .load(cnt_load),
        .load_val(psc_start), .tick_in(div_uf), .tick_out(psc_uf)
    );

    swk_downcnt #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(settling), .load(cnt_load),
        .load_val(tmr_start), .tick_in(psc_uf), .tick_out(tmr_uf)
    );

    // R4: the oscillator restarts only in answer to a wake interrupt
    p_osc_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> $past(wake_irq));

    // R2: stop gates the CPU clock and the oscillator together
    p_stop_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);

    // R5: a timer underflow comes only with a prescaler underflow
    p_cascade_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf |-> (psc_uf && div_uf));
endmodule

// File: tb/tb_stopwake_ctrl.sv
module tb_stopwake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cpu_clk_en, osc_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stopwake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en)
    );

    // {inhibit, timer reload, prescaler reload, expected settle cycles}
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'd5,   8'd7,   16'd8192},  // R5 written values unused
        {1'b0, 8'd0,   8'd0,   16'd8192},  // R5
        {1'b1, 8'd0,   8'd0,   16'd16},    // R6 shortest
        {1'b1, 8'd2,   8'd3,   16'd192},   // R6 asymmetric
        {1'b1, 8'd0,   8'd9,   16'd160},   // R6 prescaler only
        {1'b1, 8'd1,   8'd255, 16'd8192}   // R6 equals defaults
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // wake from STOP, return cycles until cpu_clk_en rises; inject pulses at cycle inj
    task automatic settle(input int inj, output int n);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        check("R4 osc_en after wake", int'(osc_en), 1);
        check("R4 cpu_clk_en after wake", int'(cpu_clk_en), 0);
        n = 0;
        while (!cpu_clk_en && n < 20000) begin
            if (inj > 0 && n == inj) begin
                wake_irq = 1'b1;
                stop_req = 1'b1;
            end
            @(negedge clk);
            wake_irq = 1'b0;
            stop_req = 1'b0;
            n++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 cpu_clk_en in reset", int'(cpu_clk_en), 1);
        check("R1 osc_en in reset", int'(osc_en), 1);
        rst_n = 1'b1;
        idle(2);
        check("R1 cpu_clk_en after reset", int'(cpu_clk_en), 1);

        // R9: wake while running has no effect
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        idle(2);
        check("R9 cpu_clk_en after wake in run", int'(cpu_clk_en), 1);
        check("R9 osc_en after wake in run", int'(osc_en), 1);

        for (int v = 0; v < NV; v++) begin
            wr(2'd0, VEC[v][31:24]);
            wr(2'd1, VEC[v][23:16]);
            wr(2'd2, {7'd0, VEC[v][32]});
            pulse_stop();
            check("R2 cpu_clk_en in stop", int'(cpu_clk_en), 0);
            check("R2 osc_en in stop", int'(osc_en), 0);
            idle(5);
            check("R2 still stopped", int'(osc_en), 0);
            settle(0, n);
            check(VEC[v][32] ? "R6 settle length" : "R5 settle length",
                  n, int'(VEC[v][15:0]));
            idle(2);
        end

        // R8: wake and stop pulses during settling, default reload
        wr(2'd2, 8'd0);
        pulse_stop();
        settle(100, n);
        check("R8 settle length with mid pulses", n, 8192);
        idle(2);
        check("R8 run after settle", int'(cpu_clk_en), 1);

        // R3 and R7: stop-disable blocks, cannot be cleared
        wr(2'd2, 8'h02);
        pulse_stop();
        idle(2);
        check("R3 stop ignored cpu_clk_en", int'(cpu_clk_en), 1);
        check("R3 stop ignored osc_en", int'(osc_en), 1);
        wr(2'd2, 8'h00);
        pulse_stop();
        idle(2);
        check("R7 stop-disable kept cpu_clk_en", int'(cpu_clk_en), 1);
        check("R7 stop-disable kept osc_en", int'(osc_en), 1);

        // R1: reset clears stop-disable and inhibit
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        pulse_stop();
        check("R1 stop accepted after reset", int'(osc_en), 0);
        settle(0, n);
        check("R1 inhibit cleared by reset", n, 8192);

        finish_run();
    end
endmodule